// File: doc/BRIEF.md
# Condition-Code Branch Resolution Unit

This block makes the branch decision for a single-issue, in-order 32-bit pipeline whose branches test stored condition flags instead of comparing registers. It holds the four scalar flags: zero, negative, positive and overflow. An instruction in the execute stage refreshes them from its result when its update bit is set. A branch presented in the decode stage selects one of eight conditions with a 3-bit field. The block evaluates that condition, computes the target address and produces the return address for calls.

Two wide variants apply the same condition to each subfield of a SIMD datapath, using that subfield's own four flags. One is taken only when every subfield matches. The other is taken only when no subfield matches. When the execute-stage instruction is updating the flags in the same cycle as a branch, the new flags are forwarded into the decision. The decision, target and link request are registered and appear one cycle after the branch is presented.

Top module: `brr_unit`

## Requirements
- R1: When `ex_upd` is 1, `flags_o` on the next cycle is {OV, GT, LT, EQ} (bit 3 down to bit 0). EQ = result is zero, LT = result bit 31 is set, GT = result is nonzero with bit 31 clear, OV = `ex_ovf`.
- R2: When `ex_upd` is 0, `flags_o` keeps its value whatever `ex_result` and `ex_ovf` carry.
- R3: A branch presented in a cycle with `ex_upd` = 1 is decided on the flags derived from that cycle's `ex_result`/`ex_ovf`, not on the stored ones.
- R4: Condition codes in `br_cond`: 0 always, 1 zero, 2 not zero, 3 overflow, 4 negative, 5 positive or zero, 6 positive, 7 negative or zero. For `br_kind` = 0 the branch is taken when the selected condition holds on the scalar flags.
- R5: With `br_base_sel` = 0, the target is `br_pc` plus the sign-extended `br_off` shifted left by 2, with bits 1:0 forced to 0.
- R6: With `br_base_sel` = 1, the target is `br_base` plus the sign-extended `br_off` shifted left by 2, with bits 1:0 forced to 0.
- R7: When `br_link` is 1 and the branch is taken, `res_link_we` is 1, `res_link_reg` is 31 and `res_link_addr` is `br_pc` + 8. An untaken branch never requests a link write.
- R8: For `br_kind` = 1, the branch is taken only when the condition holds on every lane's {ov, gt, lt, eq} flags.
- R9: For `br_kind` = 2, the branch is taken only when the condition holds on no lane.
- R10: For `br_kind` = 3, the branch is never taken. `res_valid` is 1 exactly one cycle after each cycle with `br_valid` = 1, and only then.
- R11: While reset is held and after its release, `flags_o` is 0 and `res_valid` is 0 until a flag update or a branch occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ex_upd | input | 1 | Execute-stage instruction updates the flags |
| ex_result | input | 32 | Execute-stage result |
| ex_ovf | input | 1 | Execute-stage overflow |
| wide_eq | input | 8 | Per-lane zero flags of the wide datapath |
| wide_lt | input | 8 | Per-lane negative flags |
| wide_gt | input | 8 | Per-lane positive flags |
| wide_ov | input | 8 | Per-lane overflow flags |
| br_valid | input | 1 | Branch present in decode |
| br_kind | input | 2 | 0 scalar, 1 all lanes, 2 no lane, 3 never |
| br_cond | input | 3 | Condition code |
| br_base_sel | input | 1 | 0 PC-relative, 1 base register |
| br_link | input | 1 | Save return address |
| br_pc | input | 32 | Address of the branch |
| br_base | input | 32 | Base register value |
| br_off | input | 16 | Offset in instruction words |
| flags_o | output | 4 | Stored scalar flags {OV,GT,LT,EQ} |
| res_valid | output | 1 | Decision valid |
| res_taken | output | 1 | Branch taken |
| res_target | output | 32 | Target address |
| res_link_we | output | 1 | Write the return address |
| res_link_reg | output | 5 | Link register index |
| res_link_addr | output | 32 | Return address |

## Verification
The assertions check on every cycle that the stored flags hold when no update is requested, and that after an update exactly one of zero, negative and positive is set. They also check that targets stay word-aligned, that a link write only accompanies a taken branch with register 31 and the branch address plus 8, that the never kind is never taken, and that taken wide branches agree with the lane flags. The bench scenarios show what a property cannot express compactly: the full condition table on several flag states, same-cycle forwarding against a stale stored value, sign-extended negative offsets in both address modes, and the all and none decisions on mixed lane patterns.

// File: rtl/brr_pkg.sv
package brr_pkg;

  typedef struct packed {
    logic ov;
    logic gt;
    logic lt;
    logic eq;
  } flags_t;

  typedef enum logic [2:0] {
    CC_AL = 3'd0,
    CC_ZR = 3'd1,
    CC_NZ = 3'd2,
    CC_OV = 3'd3,
    CC_NG = 3'd4,
    CC_PZ = 3'd5,
    CC_PS = 3'd6,
    CC_NZE = 3'd7
  } cond_e;

  typedef enum logic [1:0] {
    KIND_SCALAR = 2'd0,
    KIND_ALL    = 2'd1,
    KIND_NONE   = 2'd2,
    KIND_NEVER  = 2'd3
  } kind_e;

  localparam int LINK_IDX  = 31;
  localparam int LINK_STEP = 8;

  function automatic logic cond_hit(input logic [2:0] c, input flags_t f);
    logic hit;
    case (c)
      CC_AL:   hit = 1'b1;
      CC_ZR:   hit = f.eq;
      CC_NZ:   hit = ~f.eq;
      CC_OV:   hit = f.ov;
      CC_NG:   hit = f.lt;
      CC_PZ:   hit = f.gt | f.eq;
      CC_PS:   hit = f.gt;
      default: hit = f.lt | f.eq;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/brr_flag_store.sv
module brr_flag_store
  import brr_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd,
  input  logic [DW-1:0] result,
  input  logic          ovf,
  output flags_t        flags_q,
  output flags_t        flags_fwd
);

  flags_t fresh;
  flags_t flags_d;
  logic   flags_en;

  always_comb begin
    fresh.eq = (result == '0);
    fresh.lt = result[DW-1];
    fresh.gt = ~result[DW-1] & (|result);
    fresh.ov = ovf;
    flags_en = upd;
    flags_d  = fresh;
    flags_fwd = upd ? fresh : flags_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  a_r2_hold_without_update: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(flags_q));

  a_r1_one_sign_after_update: assert property (@(posedge clk) disable iff (!rst_n)
    upd |=> $onehot({flags_q.gt, flags_q.lt, flags_q.eq}));

  a_r1_sign_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flags_q.gt, flags_q.lt, flags_q.eq}));

endmodule

// File: rtl/brr_cond_eval.sv
module brr_cond_eval
  import brr_pkg::*;
#(
  parameter int LANES = 8
) (
  input  logic [2:0]       cond,
  input  logic [1:0]       kind,
  input  flags_t           scal,
  input  logic [LANES-1:0] w_eq,
  input  logic [LANES-1:0] w_lt,
  input  logic [LANES-1:0] w_gt,
  input  logic [LANES-1:0] w_ov,
  output logic             taken
);

  logic [LANES-1:0] lane_hit;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    flags_t lane_f;
    always_comb begin
      lane_f.ov   = w_ov[i];
      lane_f.gt   = w_gt[i];
      lane_f.lt   = w_lt[i];
      lane_f.eq   = w_eq[i];
      lane_hit[i] = cond_hit(cond, lane_f);
    end
  end

  always_comb begin
    case (kind)
      KIND_SCALAR: taken = cond_hit(cond, scal);
      KIND_ALL:    taken = &lane_hit;
      KIND_NONE:   taken = ~(|lane_hit);
      default:     taken = 1'b0;
    endcase
  end

endmodule

// File: rtl/brr_target_gen.sv
module brr_target_gen
  import brr_pkg::*;
#(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] base,
  input  logic          base_sel,
  input  logic [OW-1:0] off,
  output logic [AW-1:0] target,
  output logic [AW-1:0] link_addr
);

  localparam int EXT_W = AW - OW;

  logic [AW-1:0] off_ext;
  logic [AW-1:0] off_bytes;
  logic [AW-1:0] origin;
  logic [AW-1:0] sum;

  always_comb begin
    off_ext   = {{EXT_W{off[OW-1]}}, off};
    off_bytes = off_ext << 2;
    origin    = base_sel ? base : pc;
    sum       = origin + off_bytes;
    target    = {sum[AW-1:2], 2'b00};
    link_addr = pc + AW'(LINK_STEP);
  end

endmodule

// File: rtl/brr_unit.sv
module brr_unit
  import brr_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int OW    = 16,
  parameter int LANES = 8,
  parameter int RIW   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ex_upd,
  input  logic [DW-1:0]    ex_result,
  input  logic             ex_ovf,
  input  logic [LANES-1:0] wide_eq,
  input  logic [LANES-1:0] wide_lt,
  input  logic [LANES-1:0] wide_gt,
  input  logic [LANES-1:0] wide_ov,
  input  logic             br_valid,
  input  logic [1:0]       br_kind,
  input  logic [2:0]       br_cond,
  input  logic             br_base_sel,
  input  logic             br_link,
  input  logic [AW-1:0]    br_pc,
  input  logic [AW-1:0]    br_base,
  input  logic [OW-1:0]    br_off,
  output logic [3:0]       flags_o,
  output logic             res_valid,
  output logic             res_taken,
  output logic [AW-1:0]    res_target,
  output logic             res_link_we,
  output logic [RIW-1:0]   res_link_reg,
  output logic [AW-1:0]    res_link_addr
);

  logic rs_meta, rs_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_n    <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_n    <= rs_meta;
    end
  end

  flags_t flags_q, flags_fwd;

  brr_flag_store #(.DW(DW)) u_flags (
    .clk      (clk),
    .rst_n    (rs_n),
    .upd      (ex_upd),
    .result   (ex_result),
    .ovf      (ex_ovf),
    .flags_q  (flags_q),
    .flags_fwd(flags_fwd)
  );

  logic taken_c;

  brr_cond_eval #(.LANES(LANES)) u_cond (
    .cond (br_cond),
    .kind (br_kind),
    .scal (flags_fwd),
    .w_eq (wide_eq),
    .w_lt (wide_lt),
    .w_gt (wide_gt),
    .w_ov (wide_ov),
    .taken(taken_c)
  );

  logic [AW-1:0] target_c, link_c;

  brr_target_gen #(.AW(AW), .OW(OW)) u_tgt (
    .pc       (br_pc),
    .base     (br_base),
    .base_sel (br_base_sel),
    .off      (br_off),
    .target   (target_c),
    .link_addr(link_c)
  );

  logic          valid_d, taken_d, lwe_d, pay_en;
  logic [AW-1:0] target_d, laddr_d;

  always_comb begin
    valid_d  = br_valid;
    pay_en   = br_valid;
    taken_d  = taken_c;
    lwe_d    = taken_c & br_link;
    target_d = target_c;
    laddr_d  = link_c;
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      res_valid <= 1'b0;
    end else begin
      res_valid <= valid_d;
    end
  end

  always_ff @(posedge clk or negedge rs_n) begin
    if (!rs_n) begin
      res_taken     <= 1'b0;
      res_link_we   <= 1'b0;
      res_target    <= '0;
      res_link_addr <= '0;
    end else if (pay_en) begin
      res_taken     <= taken_d;
      res_link_we   <= lwe_d;
      res_target    <= target_d;
      res_link_addr <= laddr_d;
    end
  end

  assign res_link_reg = RIW'(LINK_IDX);
  assign flags_o      = flags_q;

  a_r5_target_aligned: assert property (@(posedge clk) disable iff (!rs_n)
    res_valid |-> (res_target[1:0] == 2'b00));

  a_r7_link_needs_taken: assert property (@(posedge clk) disable iff (!rs_n)
    (res_valid && res_link_we) |-> (res_taken && res_link_reg == RIW'(LINK_IDX)));

  a_r7_link_address: assert property (@(posedge clk) disable iff (!rs_n)
    (br_valid && br_link) |=> (res_link_addr == $past(br_pc) + AW'(LINK_STEP)));

  a_r10_never_kind: assert property (@(posedge clk) disable iff (!rs_n)
    (br_valid && br_kind == KIND_NEVER) |=> !res_taken);

  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rs_n)
    !br_valid |=> !res_valid);

  a_r8_all_lanes_zero: assert property (@(posedge clk) disable iff (!rs_n)
    (br_valid && br_kind == KIND_ALL && br_cond == CC_ZR && taken_c) |-> (&wide_eq));

  a_r9_no_lane_zero: assert property (@(posedge clk) disable iff (!rs_n)
    (br_valid && br_kind == KIND_NONE && br_cond == CC_ZR && taken_c) |-> !(|wide_eq));

endmodule

// File: tb/sim_brr_unit.sv
module sim_brr_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ex_upd, ex_ovf;
  logic [31:0] ex_result;
  logic [7:0]  wide_eq, wide_lt, wide_gt, wide_ov;
  logic        br_valid, br_base_sel, br_link;
  logic [1:0]  br_kind;
  logic [2:0]  br_cond;
  logic [31:0] br_pc, br_base;
  logic [15:0] br_off;
  logic [3:0]  flags_o;
  logic        res_valid, res_taken, res_link_we;
  logic [31:0] res_target, res_link_addr;
  logic [4:0]  res_link_reg;

  always #5 clk = ~clk;

  brr_unit u0 (
    .clk(clk), .rst_n(rst_n), .ex_upd(ex_upd), .ex_result(ex_result), .ex_ovf(ex_ovf),
    .wide_eq(wide_eq), .wide_lt(wide_lt), .wide_gt(wide_gt), .wide_ov(wide_ov),
    .br_valid(br_valid), .br_kind(br_kind), .br_cond(br_cond), .br_base_sel(br_base_sel),
    .br_link(br_link), .br_pc(br_pc), .br_base(br_base), .br_off(br_off),
    .flags_o(flags_o), .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target),
    .res_link_we(res_link_we), .res_link_reg(res_link_reg), .res_link_addr(res_link_addr)
  );

  typedef struct {
    bit          taken;
    logic [31:0] target;
    bit          lwe;
    logic [31:0] laddr;
    string       req;
  } exp_t;

  exp_t     sb[$];
  int       checks = 0;
  int       fails  = 0;
  bit [3:0] ref_flags = 4'b0;
  bit       mon_on = 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit ref_hit(input logic [2:0] c, input bit [3:0] f);
    case (c)
      3'd0: return 1'b1;
      3'd1: return f[0];
      3'd2: return !f[0];
      3'd3: return f[3];
      3'd4: return f[1];
      3'd5: return f[2] || f[0];
      3'd6: return f[2];
      default: return f[1] || f[0];
    endcase
  endfunction

  function automatic bit [3:0] flags_of(input logic [31:0] r, input bit o);
    return {o, (!r[31] && r != 0), r[31], (r == 0)};
  endfunction

  task automatic idle_inputs();
    ex_upd = 0; ex_result = 0; ex_ovf = 0; br_valid = 0; br_kind = 0; br_cond = 0;
    br_base_sel = 0; br_link = 0; br_pc = 0; br_base = 0; br_off = 0;
    wide_eq = 0; wide_lt = 0; wide_gt = 0; wide_ov = 0;
  endtask

  task automatic drive(input logic [1:0] kind, input logic [2:0] cond, input bit bsel, input bit link,
                       input logic [31:0] pc, input logic [31:0] base, input logic [15:0] off,
                       input string req, input bit upd = 0, input logic [31:0] res = 0, input bit ovf = 0,
                       input logic [7:0] weq = 0, input logic [7:0] wlt = 0,
                       input logic [7:0] wgt = 0, input logic [7:0] wov = 0);
    exp_t     e;
    bit [3:0] eff;
    bit       all_m, any_m;
    logic [31:0] so;
    @(negedge clk);
    ex_upd = upd; ex_result = res; ex_ovf = ovf;
    wide_eq = weq; wide_lt = wlt; wide_gt = wgt; wide_ov = wov;
    br_valid = 1; br_kind = kind; br_cond = cond; br_base_sel = bsel; br_link = link;
    br_pc = pc; br_base = base; br_off = off;
    eff = upd ? flags_of(res, ovf) : ref_flags;
    all_m = 1; any_m = 0;
    for (int i = 0; i < 8; i++) begin
      bit h;
      h = ref_hit(cond, {wov[i], wgt[i], wlt[i], weq[i]});
      all_m = all_m && h;
      any_m = any_m || h;
    end
    case (kind)
      2'd0: e.taken = ref_hit(cond, eff);
      2'd1: e.taken = all_m;
      2'd2: e.taken = !any_m;
      default: e.taken = 0;
    endcase
    so = {{16{off[15]}}, off};
    e.target = ((bsel ? base : pc) + (so << 2)) & 32'hFFFF_FFFC;
    e.lwe    = e.taken && link;
    e.laddr  = pc + 32'd8;
    e.req    = req;
    sb.push_back(e);
    if (upd) ref_flags = flags_of(res, ovf);
  endtask

  task automatic upd_only(input logic [31:0] res, input bit ovf, input bit upd);
    @(negedge clk);
    idle_inputs();
    ex_upd = upd; ex_result = res; ex_ovf = ovf;
    if (upd) ref_flags = flags_of(res, ovf);
  endtask

  task automatic chk_flags(input string req);
    @(negedge clk);
    idle_inputs();
    check(flags_o == ref_flags, req, {28'b0, flags_o}, {28'b0, ref_flags});
  endtask

  always @(negedge clk) begin
    if (mon_on && res_valid) begin
      if (sb.size() == 0) begin
        check(1'b0, "R10 unexpected result", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check(res_taken == e.taken, {e.req, " taken"}, {31'b0, res_taken}, {31'b0, e.taken});
        check(res_target == e.target, {e.req, " target"}, res_target, e.target);
        check(res_link_we == e.lwe, {e.req, " R7 link_we"}, {31'b0, res_link_we}, {31'b0, e.lwe});
        if (e.lwe) begin
          check(res_link_addr == e.laddr, {e.req, " R7 link_addr"}, res_link_addr, e.laddr);
          check(res_link_reg == 5'd31, {e.req, " R7 link_reg"}, {27'b0, res_link_reg}, 32'd31);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(flags_o == 4'b0, "R11 flags in reset", {28'b0, flags_o}, 32'd0);
    check(res_valid == 1'b0, "R11 valid in reset", {31'b0, res_valid}, 32'd0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    check(flags_o == 4'b0, "R11 flags after release", {28'b0, flags_o}, 32'd0);
    check(res_valid == 1'b0, "R11 valid after release", {31'b0, res_valid}, 32'd0);
    mon_on = 1;

    upd_only(32'h0, 0, 1);           chk_flags("R1 zero result");
    upd_only(32'h8000_0000, 1, 1);   chk_flags("R1 negative overflow");
    upd_only(32'h5, 0, 1);           chk_flags("R1 positive");
    upd_only(32'h0, 1, 0);           chk_flags("R2 no update ignored");
    check(flags_o == 4'b0100, "R2 positive kept", {28'b0, flags_o}, 32'h4);

    for (int c = 0; c < 8; c++)
      drive(2'd0, 3'(c), 0, 0, 32'h1000, 0, 16'd4, "R4 scalar on positive");
    upd_only(32'h0, 0, 1);
    drive(2'd0, 3'd7, 0, 0, 32'h1000, 0, 16'd1, "R4 le on zero");
    drive(2'd0, 3'd5, 0, 0, 32'h1000, 0, 16'd1, "R4 ge on zero");
    drive(2'd0, 3'd2, 0, 0, 32'h1000, 0, 16'd1, "R4 ne on zero");
    drive(2'd0, 3'd4, 0, 0, 32'h1000, 0, 16'd1, "R4 lt on zero");

    drive(2'd0, 3'd4, 0, 0, 32'h1100, 0, 16'd2, "R3 forward negative", 1, 32'hFFFF_FFFD, 0);
    drive(2'd0, 3'd4, 0, 0, 32'h1104, 0, 16'd2, "R3 stored negative");
    drive(2'd0, 3'd6, 0, 0, 32'h1108, 0, 16'd2, "R3 forward positive", 1, 32'd7, 0);
    drive(2'd0, 3'd3, 0, 0, 32'h110C, 0, 16'd2, "R3 forward overflow", 1, 32'd1, 1);
    drive(2'd0, 3'd1, 0, 0, 32'h1110, 0, 16'd2, "R3 forward zero", 1, 32'd0, 0);

    drive(2'd0, 3'd0, 0, 0, 32'h2000_0008, 32'h0, 16'hFFFE, "R5 pc negative offset");
    drive(2'd0, 3'd0, 0, 0, 32'h2000_0003, 32'h0, 16'h0001, "R5 pc unaligned");
    drive(2'd0, 3'd0, 1, 0, 32'h2000_0000, 32'h0000_4003, 16'd3, "R6 base unaligned");
    drive(2'd0, 3'd0, 1, 0, 32'h2000_0000, 32'h0000_0100, 16'h8000, "R6 base negative offset");

    drive(2'd0, 3'd0, 0, 1, 32'h3000, 0, 16'd5, "R7 taken call");
    drive(2'd0, 3'd2, 0, 1, 32'h3010, 0, 16'd5, "R7 untaken call");

    drive(2'd1, 3'd1, 0, 0, 32'h4000, 0, 16'd1, "R8 all zero", 0, 0, 0, 8'hFF);
    drive(2'd1, 3'd1, 0, 0, 32'h4000, 0, 16'd1, "R8 one lane nonzero", 0, 0, 0, 8'hFE);
    drive(2'd1, 3'd5, 0, 0, 32'h4000, 0, 16'd1, "R8 all ge mixed", 0, 0, 0, 8'hF0, 8'h00, 8'h0F);
    drive(2'd1, 3'd3, 0, 0, 32'h4000, 0, 16'd1, "R8 ov partial", 0, 0, 0, 8'h00, 8'h00, 8'h00, 8'h7F);

    drive(2'd2, 3'd4, 0, 0, 32'h5000, 0, 16'd1, "R9 none negative", 0, 0, 0, 8'h00, 8'h00);
    drive(2'd2, 3'd4, 0, 0, 32'h5000, 0, 16'd1, "R9 one negative", 0, 0, 0, 8'h00, 8'h10);
    drive(2'd2, 3'd0, 0, 0, 32'h5000, 0, 16'd1, "R9 none always");
    drive(2'd2, 3'd1, 0, 0, 32'h5000, 0, 16'd1, "R9 none zero clear", 0, 0, 0, 8'h00, 8'hFF);

    drive(2'd3, 3'd0, 0, 1, 32'h6000, 0, 16'd1, "R10 never kind");
    upd_only(32'h0, 0, 0);
    repeat (4) @(negedge clk);
    check(sb.size() == 0, "R10 all results seen", sb.size(), 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule